// File: doc/BRIEF.md
# Half-Bridge Over-Current Protection Sequencer

This block decides when the two gate outputs of a half-bridge power stage may switch. It watches the over-current comparator result for each transistor and the two supply-good indications. It also sees the present on/off state of each gate. From these it drives a single shutdown request to the gate drivers and a status flag for a host controller.

A hysteretic timer stands in for an external timing capacitor. It is an up/down counter that charges and discharges in equal steps between zero and a full-scale count. Two fractions of full scale act as the thresholds: 30 % is the lower one and 70 % the upper one. The timer sets the power-up delay and the retry period after a fault.

The block has two fault modes. In auto-retry mode it restarts switching by itself after a fault. In latched mode it stays off after a fault until it receives a long enough external reset pulse, and it also needs that pulse once after power-up.

Top module: `ocp_sequencer`

## Requirements
- R1: While either supply flag (`uv_vdd`, `uv_vcc`) is 1, `shutdown` is 1 and `oc_status` is 0. Once both are 0, `shutdown` stays 1 while the timer climbs from zero in steps of `RAMP_STEP`. The count of clock cycles from the first edge with both supplies good is exactly one plus the number of steps needed to exceed the upper threshold. With defaults this is 72 cycles. After that, in auto-retry mode (`latch_mode` = 0), `shutdown` returns to 0.
- R2: An over-current flag is accepted only after its gate (`ho_on` or `lo_on`) has been 1 for `BLANK_CYC` rising edges without a break; 45 edges is 450 ns at 100 MHz. Before that the flag has no effect on `shutdown`.
- R3: `oc_hi` is honoured only while `ho_on` is 1, and `oc_lo` only while `lo_on` is 1. A flag raised while only the opposite gate is on leaves `shutdown` at 0.
- R4: When an accepted over-current appears, `shutdown` goes to 1 in the same cycle, before any clock edge.
- R5: In auto-retry mode, a fault starts a ramp down from full scale. The cycle after the timer is seen below the lower threshold, the ramp reverses upward. The cycle after it is seen above the upper threshold, switching resumes. `shutdown` is 1 for exactly (down steps + up steps + 3) cycles, counted from the cycle the fault is first seen. The timer never exceeds `FULL_SCALE`.
- R6: `oc_status` goes to 1 on the edge that accepts the fault and stays 1 for exactly (down steps + 1) cycles. It clears only when the discharge reaches the lower threshold.
- R7: In auto-retry mode, an over-current that is still present after switching resumes starts the same sequence again, with identical durations, each time its gate turns on.
- R8: In latched mode (`latch_mode` = 1), an accepted over-current keeps both `shutdown` and `oc_status` at 1 for as long as no reset and no undervoltage occurs.
- R9: `ext_reset` takes effect only if it stays 1 for at least `RST_MIN_CYC` rising edges (200 ns); shorter pulses change nothing. A qualified reset clears `oc_status`, forces the timer to zero and restarts the upward ramp. `shutdown` is then released after the same delay as in R1, counted from the first edge after the reset ends.
- R10: In latched mode, the power-up ramp alone does not release `shutdown`; a qualified reset is needed first.
- R11: An undervoltage during operation sets `shutdown` at once, clears `oc_status` on the next edge, and restarts the power-up sequence of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz for the stated time windows |
| rst_n | input | 1 | Asynchronous reset, active low |
| latch_mode | input | 1 | 0 = auto-retry after a fault, 1 = latched until reset |
| oc_hi | input | 1 | High-side over-current comparator result |
| oc_lo | input | 1 | Low-side over-current comparator result |
| ho_on | input | 1 | High-side gate is currently on |
| lo_on | input | 1 | Low-side gate is currently on |
| uv_vdd | input | 1 | Input-side supply below its lockout level |
| uv_vcc | input | 1 | Gate-side supply below its lockout level |
| ext_reset | input | 1 | External reset request for the protection latch |
| shutdown | output | 1 | 1 forces both gates off |
| oc_status | output | 1 | 1 while an over-current event is latched |

## Verification
The bench targets the edges of the blanking window and of the reset filter. At the blanking edge, a design that counted one edge too few or too many would trip one cycle early or late. At the filter edge, a design that counted wrongly would accept a 19-edge pulse or reject a 20-edge one.

Shutdown and status durations are measured cycle by cycle against counts the bench derives from the thresholds. This exposes a comparison made with the wrong inequality, a turnaround that skips a cycle, and a latch cleared at the wrong end of the ramp.

Other checks cover a flag raised on the opposite side, a retry with the fault still present, and an undervoltage that arrives while a fault is latched. These catch a sequencer that leaves stale state behind.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [2:0] {
    SEQ_UVLO,
    SEQ_POWERUP,
    SEQ_RUN,
    SEQ_DISCH,
    SEQ_CHARGE,
    SEQ_HOLD
  } seq_state_e;

  // threshold as a percentage of full scale
  function automatic int threshold(input int full, input int pct);
    return (full * pct) / 100;
  endfunction

  // charge step, clamped at full scale
  function automatic int ramp_up(input int level, input int step, input int full);
    if (level + step > full) return full;
    return level + step;
  endfunction

  // discharge step, clamped at zero
  function automatic int ramp_dn(input int level, input int step);
    if (level < step) return 0;
    return level - step;
  endfunction

endpackage

// File: rtl/ocp_blank_gate.sv
module ocp_blank_gate #(
  parameter int BLANK_CYC = 45
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_on,
  input  logic oc_flag,
  output logic oc_valid
);
  localparam int CW = $clog2(BLANK_CYC + 1);

  logic [CW-1:0] on_cnt_q;
  logic          settled;

  assign settled = (on_cnt_q == CW'(BLANK_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        on_cnt_q <= '0;
    else if (!gate_on) on_cnt_q <= '0;
    else if (!settled) on_cnt_q <= on_cnt_q + CW'(1);
  end

  assign oc_valid = gate_on && settled && oc_flag;
endmodule

// File: rtl/ocp_pulse_qual.sv
module ocp_pulse_qual #(
  parameter int MIN_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  output logic pulse_ok
);
  localparam int CW = $clog2(MIN_CYC + 1);

  logic [CW-1:0] hold_cnt_q;

  assign pulse_ok = (hold_cnt_q == CW'(MIN_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hold_cnt_q <= '0;
    else if (!pulse_in) hold_cnt_q <= '0;
    else if (!pulse_ok) hold_cnt_q <= hold_cnt_q + CW'(1);
  end
endmodule

// File: rtl/ocp_ramp_timer.sv
module ocp_ramp_timer #(
  parameter int FULL_SCALE = 1000,
  parameter int RAMP_STEP  = 10,
  parameter int TW         = $clog2(FULL_SCALE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          charge,
  input  logic          discharge,
  output logic [TW-1:0] level
);
  logic [TW-1:0] level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         level_q <= '0;
    else if (clear)     level_q <= '0;
    else if (charge)    level_q <= TW'(ocp_pkg::ramp_up(int'(level_q), RAMP_STEP, FULL_SCALE));
    else if (discharge) level_q <= TW'(ocp_pkg::ramp_dn(int'(level_q), RAMP_STEP));
  end

  assign level = level_q;
endmodule

// File: rtl/ocp_sequencer.sv
module ocp_sequencer #(
  parameter int FULL_SCALE  = 1000,
  parameter int RAMP_STEP   = 10,
  parameter int LOW_PCT     = 30,
  parameter int HIGH_PCT    = 70,
  parameter int BLANK_CYC   = 45,
  parameter int RST_MIN_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic latch_mode,
  input  logic oc_hi,
  input  logic oc_lo,
  input  logic ho_on,
  input  logic lo_on,
  input  logic uv_vdd,
  input  logic uv_vcc,
  input  logic ext_reset,
  output logic shutdown,
  output logic oc_status
);
  import ocp_pkg::*;

  localparam int TW = $clog2(FULL_SCALE + 1);
  localparam logic [TW-1:0] LO_TH = TW'(threshold(FULL_SCALE, LOW_PCT));
  localparam logic [TW-1:0] HI_TH = TW'(threshold(FULL_SCALE, HIGH_PCT));
  localparam int NSIDE = 2;  // index 0 = low side, 1 = high side

  // named internal events
  logic [NSIDE-1:0] gate_vec, flag_vec, valid_vec;
  logic oc_lo_ok, oc_hi_ok, oc_event;
  logic uv_any, rst_ok, in_run;
  logic [TW-1:0] timer_q;

  seq_state_e st_q, st_d;
  logic tmr_clr, tmr_chg, tmr_dis;
  logic latch_q, latch_set, latch_clr;

  assign gate_vec = {ho_on, lo_on};
  assign flag_vec = {oc_hi, oc_lo};

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    ocp_blank_gate #(.BLANK_CYC(BLANK_CYC)) u_blank (
      .clk     (clk),
      .rst_n   (rst_n),
      .gate_on (gate_vec[s]),
      .oc_flag (flag_vec[s]),
      .oc_valid(valid_vec[s])
    );
  end

  assign oc_lo_ok = valid_vec[0];
  assign oc_hi_ok = valid_vec[1];
  assign oc_event = |valid_vec;
  assign uv_any   = uv_vdd || uv_vcc;

  ocp_pulse_qual #(.MIN_CYC(RST_MIN_CYC)) u_rstq (
    .clk     (clk),
    .rst_n   (rst_n),
    .pulse_in(ext_reset),
    .pulse_ok(rst_ok)
  );

  ocp_ramp_timer #(.FULL_SCALE(FULL_SCALE), .RAMP_STEP(RAMP_STEP), .TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (tmr_clr),
    .charge   (tmr_chg),
    .discharge(tmr_dis),
    .level    (timer_q)
  );

  always_comb begin
    st_d      = st_q;
    tmr_clr   = 1'b0;
    tmr_chg   = 1'b0;
    tmr_dis   = 1'b0;
    latch_set = 1'b0;
    latch_clr = 1'b0;
    if (uv_any) begin
      st_d      = SEQ_UVLO;
      tmr_clr   = 1'b1;
      latch_clr = 1'b1;
    end else if (rst_ok && st_q != SEQ_UVLO && st_q != SEQ_POWERUP) begin
      st_d      = SEQ_CHARGE;
      tmr_clr   = 1'b1;
      latch_clr = 1'b1;
    end else begin
      unique case (st_q)
        SEQ_UVLO: st_d = SEQ_POWERUP;
        SEQ_POWERUP: begin
          if (timer_q > HI_TH) st_d = latch_mode ? SEQ_HOLD : SEQ_RUN;
          else                 tmr_chg = 1'b1;
        end
        SEQ_RUN: begin
          tmr_chg = 1'b1;
          if (oc_event) begin
            latch_set = 1'b1;
            st_d      = latch_mode ? SEQ_HOLD : SEQ_DISCH;
          end
        end
        SEQ_DISCH: begin
          if (timer_q < LO_TH) begin
            latch_clr = 1'b1;
            st_d      = SEQ_CHARGE;
          end else begin
            tmr_dis = 1'b1;
          end
        end
        SEQ_CHARGE: begin
          if (timer_q > HI_TH) st_d = SEQ_RUN;
          else                 tmr_chg = 1'b1;
        end
        SEQ_HOLD: tmr_chg = 1'b1;
        default:  st_d = SEQ_UVLO;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEQ_UVLO;
      latch_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (latch_clr)      latch_q <= 1'b0;
      else if (latch_set) latch_q <= 1'b1;
    end
  end

  assign in_run    = (st_q == SEQ_RUN);
  assign shutdown  = uv_any || !in_run || oc_event;
  assign oc_status = latch_q;
endmodule

// File: rtl/ocp_sequencer_sva.sv
module ocp_sequencer_sva #(
  parameter int FULL_SCALE = 1000,
  parameter int LOW_PCT    = 30,
  parameter int HIGH_PCT   = 70,
  parameter int TW         = $clog2(FULL_SCALE + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          latch_mode,
  input logic          ho_on,
  input logic          lo_on,
  input logic          uv_any,
  input logic          oc_event,
  input logic          oc_hi_ok,
  input logic          oc_lo_ok,
  input logic          rst_ok,
  input logic          in_run,
  input logic [TW-1:0] timer,
  input logic          oc_status,
  input logic          shutdown
);
  localparam logic [TW-1:0] LO_TH = TW'(ocp_pkg::threshold(FULL_SCALE, LOW_PCT));
  localparam logic [TW-1:0] HI_TH = TW'(ocp_pkg::threshold(FULL_SCALE, HIGH_PCT));
  localparam logic [TW-1:0] TOP   = TW'(FULL_SCALE);

  assert_oc_forces_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    oc_event |-> shutdown);

  assert_hi_needs_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    oc_hi_ok |-> (ho_on && $past(ho_on)));

  assert_lo_needs_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    oc_lo_ok |-> (lo_on && $past(lo_on)));

  assert_release_above_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_run) |-> ($past(timer) > HI_TH));

  assert_timer_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timer <= TOP);

  assert_status_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_status) |-> $past(oc_event));

  assert_status_clears_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(oc_status) && !$past(uv_any) && !$past(rst_ok)) |-> ($past(timer) < LO_TH));

  assert_latched_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_mode && oc_status && !uv_any && !rst_ok) |=> oc_status);

  assert_uv_clears_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
    uv_any |=> !oc_status);
endmodule

bind ocp_sequencer ocp_sequencer_sva #(
  .FULL_SCALE(FULL_SCALE),
  .LOW_PCT   (LOW_PCT),
  .HIGH_PCT  (HIGH_PCT),
  .TW        (TW)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .latch_mode(latch_mode),
  .ho_on     (ho_on),
  .lo_on     (lo_on),
  .uv_any    (uv_any),
  .oc_event  (oc_event),
  .oc_hi_ok  (oc_hi_ok),
  .oc_lo_ok  (oc_lo_ok),
  .rst_ok    (rst_ok),
  .in_run    (in_run),
  .timer     (timer_q),
  .oc_status (oc_status),
  .shutdown  (shutdown)
);

// File: tb/ocp_sequencer_test.sv
`timescale 1ns/1ps
module ocp_sequencer_test;
  localparam int FULL  = 1000;
  localparam int STEP  = 10;
  localparam int LOPCT = 30;
  localparam int HIPCT = 70;
  localparam int BLANK = 45;
  localparam int RMIN  = 20;
  localparam int LO_T  = FULL * LOPCT / 100;
  localparam int HI_T  = FULL * HIPCT / 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic latch_mode = 1'b0;
  logic oc_hi = 1'b0, oc_lo = 1'b0, ho_on = 1'b0, lo_on = 1'b0;
  logic uv_vdd = 1'b1, uv_vcc = 1'b1, ext_reset = 1'b0;
  logic shutdown, oc_status;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ocp_sequencer #(.FULL_SCALE(FULL), .RAMP_STEP(STEP), .LOW_PCT(LOPCT),
                  .HIGH_PCT(HIPCT), .BLANK_CYC(BLANK), .RST_MIN_CYC(RMIN)) uut (
    .clk(clk), .rst_n(rst_n), .latch_mode(latch_mode), .oc_hi(oc_hi), .oc_lo(oc_lo),
    .ho_on(ho_on), .lo_on(lo_on), .uv_vdd(uv_vdd), .uv_vcc(uv_vcc),
    .ext_reset(ext_reset), .shutdown(shutdown), .oc_status(oc_status));

  task automatic check_eq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // steps needed to climb from a level until strictly above the upper threshold
  function automatic int steps_above(input int from);
    int v = from;
    int n = 0;
    while (v <= HI_T) begin v = v + STEP; n++; end
    return n;
  endfunction

  // steps needed to fall from full scale until strictly below the lower threshold
  function automatic int steps_below();
    int v = FULL;
    int n = 0;
    while (v >= LO_T) begin v = v - STEP; n++; end
    return n;
  endfunction

  function automatic int residue_after_fall();
    return FULL - steps_below() * STEP;
  endfunction

  // counts negedges with shutdown high until it drops
  task automatic count_release(input string tag, input int expected);
    int n = 0;
    @(negedge clk);
    while (shutdown && n < 5000) begin n++; @(negedge clk); end
    check_eq(tag, "cycles until release", n, expected);
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    check_eq("R1", "shutdown in reset", shutdown, 1);
    check_eq("R1", "status in reset", oc_status, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_eq("R1", "shutdown with undervoltage", shutdown, 1);
  endtask

  task automatic t_power_up(input string tag);
    @(negedge clk);
    uv_vdd = 1'b0;
    uv_vcc = 1'b0;
    count_release(tag, steps_above(0) + 1);
    repeat (40) @(negedge clk);
  endtask

  // turn one gate on with its flag, verify blanking, trip, and the sequence that follows
  task automatic t_trip(input bit hi_side, input bit keep_flag, input string tag);
    int blocked = 0;
    int sd_n, st_n, guard;
    @(negedge clk);
    if (hi_side) begin ho_on = 1'b1; oc_hi = 1'b1; end
    else         begin lo_on = 1'b1; oc_lo = 1'b1; end
    for (int i = 1; i < BLANK; i++) begin
      @(negedge clk);
      blocked += shutdown;
    end
    check_eq("R2", "trips inside blanking", blocked, 0);
    @(negedge clk);
    check_eq("R4", "immediate shutdown", shutdown, 1);
    check_eq("R6", "status before edge", oc_status, 0);
    @(negedge clk);
    check_eq("R4", "shutdown after edge", shutdown, 1);
    check_eq("R6", "status after edge", oc_status, 1);
    sd_n = 2;
    st_n = 1;
    ho_on = 1'b0;
    lo_on = 1'b0;
    if (!keep_flag) begin oc_hi = 1'b0; oc_lo = 1'b0; end
    if (latch_mode) begin
      sd_n = 0; st_n = 0;
      repeat (300) begin @(negedge clk); sd_n += shutdown; st_n += oc_status; end
      check_eq("R8", "latched shutdown cycles", sd_n, 300);
      check_eq("R8", "latched status cycles", st_n, 300);
    end else begin
      guard = 0;
      @(negedge clk);
      while (shutdown && guard < 5000) begin
        sd_n++; st_n += oc_status; guard++;
        @(negedge clk);
      end
      st_n += oc_status;
      check_eq(tag, "shutdown cycles", sd_n,
               steps_below() + steps_above(residue_after_fall()) + 3);
      check_eq("R6", "status cycles", st_n, steps_below() + 1);
    end
  endtask

  task automatic t_wrong_side();
    int hits = 0;
    @(negedge clk);
    ho_on = 1'b1;
    repeat (BLANK + 10) @(negedge clk);
    oc_lo = 1'b1;
    repeat (60) begin @(negedge clk); hits += shutdown; end
    oc_lo = 1'b0; ho_on = 1'b0;
    check_eq("R3", "low flag with high gate", hits, 0);
    @(negedge clk);
    lo_on = 1'b1;
    repeat (BLANK + 10) @(negedge clk);
    oc_hi = 1'b1;
    hits = 0;
    repeat (60) begin @(negedge clk); hits += shutdown; end
    oc_hi = 1'b0; lo_on = 1'b0;
    check_eq("R3", "high flag with low gate", hits, 0);
    check_eq("R3", "status after wrong side", oc_status, 0);
  endtask

  task automatic t_uv_in_run();
    @(negedge clk);
    uv_vcc = 1'b1;
    #1;
    check_eq("R11", "shutdown on undervoltage", shutdown, 1);
    repeat (5) @(negedge clk);
    check_eq("R11", "shutdown during undervoltage", shutdown, 1);
    t_power_up("R11");
  endtask

  task automatic pulse_reset(input int len);
    @(negedge clk);
    ext_reset = 1'b1;
    repeat (len) @(negedge clk);
    ext_reset = 1'b0;
  endtask

  task automatic t_latched();
    int hi_n = 0;
    @(negedge clk);
    uv_vdd = 1'b1;
    latch_mode = 1'b1;
    repeat (3) @(negedge clk);
    uv_vdd = 1'b0;
    repeat (200) begin @(negedge clk); hi_n += shutdown; end
    check_eq("R10", "held after power-up", hi_n, 200);
    check_eq("R10", "status after power-up", oc_status, 0);
    pulse_reset(RMIN - 1);
    hi_n = 0;
    repeat (100) begin @(negedge clk); hi_n += shutdown; end
    check_eq("R9", "short reset ignored", hi_n, 100);
    pulse_reset(RMIN);
    count_release("R9", steps_above(0) + 1);
    repeat (40) @(negedge clk);
    t_trip(1'b1, 1'b0, "R8");
    pulse_reset(RMIN - 1);
    repeat (5) @(negedge clk);
    check_eq("R9", "status kept after short reset", oc_status, 1);
    pulse_reset(RMIN);
    @(negedge clk);
    check_eq("R9", "status cleared by reset", oc_status, 0);
    check_eq("R9", "still off right after reset", shutdown, 1);
    count_release("R9", steps_above(0));
    repeat (40) @(negedge clk);
    t_trip(1'b0, 1'b0, "R8");
    @(negedge clk);
    uv_vdd = 1'b1;
    @(negedge clk);
    check_eq("R11", "undervoltage clears latched status", oc_status, 0);
    uv_vdd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1..: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset_state();
    t_power_up("R1");
    t_wrong_side();
    t_trip(1'b1, 1'b0, "R5");
    t_trip(1'b0, 1'b1, "R5");
    t_trip(1'b0, 1'b1, "R7");
    oc_lo = 1'b0;
    repeat (40) @(negedge clk);
    t_uv_in_run();
    t_latched();
    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule